// File: doc/BRIEF.md
# BT.656 Stream Formatter

This block turns decoded 4:2:2 picture samples into an 8-bit BT.656 byte stream, one byte per sample-clock cycle. Every line opens with an end-of-active-video timing code, continues with horizontal blanking, then a start-of-active-video timing code, then a fixed number of active bytes. Each timing code is four bytes, and the last of the four carries the field (F), vertical-blanking (V) and H flags together with their protection bits. The formatter counts lines for 525-line/60 Hz or 625-line/50 Hz interlaced timing. From that count it derives F and V, and it fills vertically blanked lines with blanking levels.

The sample clock runs free and is not locked to the incoming video. The length of horizontal blanking is therefore not fixed. The block keeps sending blanking bytes until an upstream `line_end` strobe arrives, so that length can change from line to line. Active data always starts on the byte right after the start code. In the active part of a line, even byte slots take the chroma input and odd slots take the luma input. Codes 00 and FF are clipped so that picture data can never imitate a timing code.

Top module: `bt656_fmt`

## Requirements
- R1: While `srst` is high at a clock edge, `byte_out` becomes 0x10 and the line counter returns to line 1. After `srst` falls, the first four bytes are the end code of line 1.
- R2: Each timing code is FF, 00, 00, XY. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. H is 1 in the end code and 0 in the start code, and both codes of a line carry that line's F and V.
- R3: Each line is sent in this order: end code, blanking, start code, `ACT_BYTES` active bytes. If `line_end` is high at an edge during blanking, the byte launched at that edge is the last blanking byte and the start code follows at the next edge. Blanking is therefore at least one byte and has no upper limit.
- R4: Horizontal blanking alternates 0x80 and 0x10, starting with 0x80. On lines with V=1 the active slots carry the same pattern: 0x80 in even slots and 0x10 in odd slots.
- R5: `line_end` has no effect while the end code, the start code or the active bytes are being sent.
- R6: On a line with V=0, active byte slot a carries `pix_c` when a is even and `pix_y` when a is odd. Slots 0 mod 4 are Cb and slots 2 mod 4 are Cr, in the order the upstream presents them. The inputs sampled at an edge appear on `byte_out` after that edge. A slot whose `pix_valid` is low carries the blanking level of R4.
- R7: With `CLIP_EN`=1, an active sample of 0x00 is sent as 0x01 and a sample of 0xFF is sent as 0xFE.
- R8: With `sys625`=0, F=0 on lines 4 to 265 and F=1 on all other lines. V=0 on lines 20 to 259 and on lines 283 to 522 (240 lines per field), and V=1 elsewhere.
- R9: With `sys625`=1, F=0 on lines 1 to 312 and F=1 on lines 313 to 625. V=0 on lines 23 to 310 and on lines 336 to 623 (288 lines per field), and V=1 elsewhere.
- R10: The line number advances by one at each end code. It wraps from 525 to 1 when `sys625`=0, and from 625 to 1 when `sys625`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sample clock |
| srst | input | 1 | Synchronous reset, active high |
| sys625 | input | 1 | Line standard: 0 selects 525 lines, 1 selects 625 lines |
| line_end | input | 1 | Ends horizontal blanking; the start code follows |
| pix_valid | input | 1 | Qualifies the sample for the current active slot |
| pix_y | input | 8 | Luma sample, used in odd active slots |
| pix_c | input | 8 | Chroma sample (Cb, Cr alternating), used in even active slots |
| byte_out | output | 8 | BT.656 byte stream |

## Verification
The hardest conditions to reach from the ports are the F and V transitions deep in each frame, together with the wrap of the line counter back to line 1. These cannot be observed until hundreds of complete lines have been sent. The bench therefore uses a short active line and drives full frames in both standards, followed by extra lines past the wrap. It changes the blanking length on every line, so each F, V and wrap transition is reached with odd, even, minimum and long blanking. It also raises spurious strobes outside blanking during these frames and applies a reset in the middle of a line.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

   localparam int LINE_W = 10;

   typedef enum logic [1:0] {
      PH_EAV = 2'd0,
      PH_HBL = 2'd1,
      PH_SAV = 2'd2,
      PH_ACT = 2'd3
   } phase_t;

   // Timing code fourth byte: marker, flags, then protection bits
   function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // Keep picture data away from the reserved timing codes
   function automatic logic [7:0] clip_ref(input logic [7:0] b);
      if (b == 8'h00) return 8'h01;
      if (b == 8'hFF) return 8'hFE;
      return b;
   endfunction

endpackage

// File: rtl/bt656_line_ctr.sv
module bt656_line_ctr #(
   parameter int LW           = bt656_pkg::LINE_W,
   parameter int ACT_LINES_60 = 240,
   parameter int ACT_LINES_50 = 288
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          sys625,
   input  logic          advance,
   output logic [LW-1:0] line,
   output logic          f_bit,
   output logic          v_bit
);

   localparam logic [LW-1:0] T60   = LW'(525);
   localparam logic [LW-1:0] T50   = LW'(625);
   localparam logic [LW-1:0] A60_1 = LW'(20);
   localparam logic [LW-1:0] Z60_1 = LW'(20 + ACT_LINES_60 - 1);
   localparam logic [LW-1:0] A60_2 = LW'(283);
   localparam logic [LW-1:0] Z60_2 = LW'(283 + ACT_LINES_60 - 1);
   localparam logic [LW-1:0] A50_1 = LW'(23);
   localparam logic [LW-1:0] Z50_1 = LW'(23 + ACT_LINES_50 - 1);
   localparam logic [LW-1:0] A50_2 = LW'(336);
   localparam logic [LW-1:0] Z50_2 = LW'(336 + ACT_LINES_50 - 1);
   localparam logic [LW-1:0] F60_LO = LW'(4);
   localparam logic [LW-1:0] F60_HI = LW'(265);
   localparam logic [LW-1:0] F50_LO = LW'(313);
   localparam logic [LW-1:0] ONE    = LW'(1);

   logic [LW-1:0] last_line;
   assign last_line = sys625 ? T50 : T60;

   always_ff @(posedge clk) begin
      if (srst) begin
         line <= ONE;
      end else if (advance) begin
         line <= (line >= last_line) ? ONE : line + ONE;
      end
   end

   always_comb begin
      if (sys625) begin
         f_bit = (line >= F50_LO);
         v_bit = !(((line >= A50_1) && (line <= Z50_1)) ||
                   ((line >= A50_2) && (line <= Z50_2)));
      end else begin
         f_bit = !((line >= F60_LO) && (line <= F60_HI));
         v_bit = !(((line >= A60_1) && (line <= Z60_1)) ||
                   ((line >= A60_2) && (line <= Z60_2)));
      end
   end

endmodule

// File: rtl/bt656_hseq.sv
module bt656_hseq #(
   parameter int ACT_BYTES = 1440
) (
   input  logic                clk,
   input  logic                srst,
   input  logic                line_end,
   output bt656_pkg::phase_t   phase,
   output logic [1:0]          slot,
   output logic                advance
);
   import bt656_pkg::*;

   localparam int            IW   = $clog2(ACT_BYTES);
   localparam logic [IW-1:0] LAST = IW'(ACT_BYTES - 1);
   localparam logic [IW-1:0] CODE_LAST = IW'(3);
   localparam logic [IW-1:0] STEP = IW'(1);

   logic [IW-1:0] idx;

   always_ff @(posedge clk) begin
      if (srst) begin
         phase <= PH_EAV;
         idx   <= '0;
      end else begin
         unique case (phase)
            PH_EAV: begin
               if (idx == CODE_LAST) begin
                  phase <= PH_HBL;
                  idx   <= '0;
               end else begin
                  idx <= idx + STEP;
               end
            end
            PH_HBL: begin
               // idx wraps freely here; only its parity is used
               if (line_end) begin
                  phase <= PH_SAV;
                  idx   <= '0;
               end else begin
                  idx <= idx + STEP;
               end
            end
            PH_SAV: begin
               if (idx == CODE_LAST) begin
                  phase <= PH_ACT;
                  idx   <= '0;
               end else begin
                  idx <= idx + STEP;
               end
            end
            PH_ACT: begin
               if (idx == LAST) begin
                  phase <= PH_EAV;
                  idx   <= '0;
               end else begin
                  idx <= idx + STEP;
               end
            end
            default: begin
               phase <= PH_EAV;
               idx   <= '0;
            end
         endcase
      end
   end

   assign slot    = idx[1:0];
   assign advance = (phase == PH_ACT) && (idx == LAST);

endmodule

// File: rtl/bt656_byte_mux.sv
module bt656_byte_mux #(
   parameter int CLIP_EN = 1
) (
   input  logic              clk,
   input  logic              srst,
   input  bt656_pkg::phase_t phase,
   input  logic [1:0]        slot,
   input  logic              f_bit,
   input  logic              v_bit,
   input  logic              pix_valid,
   input  logic [7:0]        pix_y,
   input  logic [7:0]        pix_c,
   output logic [7:0]        byte_out
);
   import bt656_pkg::*;

   localparam logic [7:0] LVL_C = 8'h80;
   localparam logic [7:0] LVL_Y = 8'h10;

   logic [7:0] c_use, y_use, blank_lvl, nxt;

   generate
      if (CLIP_EN != 0) begin : g_clip
         assign c_use = clip_ref(pix_c);
         assign y_use = clip_ref(pix_y);
      end else begin : g_pass
         assign c_use = pix_c;
         assign y_use = pix_y;
      end
   endgenerate

   assign blank_lvl = slot[0] ? LVL_Y : LVL_C;

   always_comb begin
      unique case (phase)
         PH_EAV, PH_SAV: begin
            unique case (slot)
               2'd0:    nxt = 8'hFF;
               2'd3:    nxt = trs_word(f_bit, v_bit, phase == PH_EAV);
               default: nxt = 8'h00;
            endcase
         end
         PH_ACT: begin
            if (!v_bit && pix_valid) nxt = slot[0] ? y_use : c_use;
            else                     nxt = blank_lvl;
         end
         default: nxt = blank_lvl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (srst) byte_out <= LVL_Y;
      else      byte_out <= nxt;
   end

endmodule

// File: rtl/bt656_fmt.sv
module bt656_fmt #(
   parameter int ACT_BYTES    = 1440,
   parameter int CLIP_EN      = 1,
   parameter int ACT_LINES_60 = 240,
   parameter int ACT_LINES_50 = 288
) (
   input  logic       clk,
   input  logic       srst,
   input  logic       sys625,
   input  logic       line_end,
   input  logic       pix_valid,
   input  logic [7:0] pix_y,
   input  logic [7:0] pix_c,
   output logic [7:0] byte_out
);
   import bt656_pkg::*;

   generate
      if ((ACT_BYTES < 4) || (ACT_BYTES % 4 != 0)) begin : g_bad_bytes
         $error("ACT_BYTES must be a positive multiple of 4");
      end
      if ((CLIP_EN != 0) && (CLIP_EN != 1)) begin : g_bad_clip
         $error("CLIP_EN must be 0 or 1");
      end
      if ((ACT_LINES_60 < 1) || (ACT_LINES_60 > 243)) begin : g_bad_l60
         $error("ACT_LINES_60 does not fit a 525-line field");
      end
      if ((ACT_LINES_50 < 1) || (ACT_LINES_50 > 288)) begin : g_bad_l50
         $error("ACT_LINES_50 does not fit a 625-line field");
      end
   endgenerate

   phase_t            phase;
   logic [1:0]        slot;
   logic              advance;
   logic [LINE_W-1:0] line;
   logic              f_bit, v_bit;

   bt656_hseq #(.ACT_BYTES(ACT_BYTES)) i_hseq (
      .clk      (clk),
      .srst     (srst),
      .line_end (line_end),
      .phase    (phase),
      .slot     (slot),
      .advance  (advance)
   );

   bt656_line_ctr #(
      .LW           (LINE_W),
      .ACT_LINES_60 (ACT_LINES_60),
      .ACT_LINES_50 (ACT_LINES_50)
   ) i_line (
      .clk     (clk),
      .srst    (srst),
      .sys625  (sys625),
      .advance (advance),
      .line    (line),
      .f_bit   (f_bit),
      .v_bit   (v_bit)
   );

   bt656_byte_mux #(.CLIP_EN(CLIP_EN)) i_mux (
      .clk       (clk),
      .srst      (srst),
      .phase     (phase),
      .slot      (slot),
      .f_bit     (f_bit),
      .v_bit     (v_bit),
      .pix_valid (pix_valid),
      .pix_y     (pix_y),
      .pix_c     (pix_c),
      .byte_out  (byte_out)
   );

endmodule

// File: rtl/bt656_fmt_chk.sv
module bt656_fmt_chk #(
   parameter int CLIP_EN = 1
) (
   input logic                        clk,
   input logic                        srst,
   input logic [7:0]                  byte_out,
   input bt656_pkg::phase_t           phase,
   input logic [bt656_pkg::LINE_W-1:0] line,
   input logic                        advance
);
   import bt656_pkg::*;

   assert_ref_zero_R2: assert property (@(posedge clk) disable iff (srst)
      ((CLIP_EN != 0) && (byte_out == 8'hFF)) |=> (byte_out == 8'h00));

   assert_xy_prot_R2: assert property (@(posedge clk) disable iff (srst)
      ((CLIP_EN != 0) && ($past(byte_out, 3) == 8'hFF) && ($past(byte_out, 2) == 8'h00) &&
       ($past(byte_out, 1) == 8'h00))
      |-> (byte_out[7] && (byte_out[3] == (byte_out[5] ^ byte_out[4])) &&
           (byte_out[2] == (byte_out[6] ^ byte_out[4])) &&
           (byte_out[1] == (byte_out[6] ^ byte_out[5])) &&
           (byte_out[0] == (byte_out[6] ^ byte_out[5] ^ byte_out[4]))));

   assert_hbl_level_R4: assert property (@(posedge clk) disable iff (srst)
      (phase == PH_HBL) |=> ((byte_out == 8'h80) || (byte_out == 8'h10)));

   assert_eav_hold_R5: assert property (@(posedge clk) disable iff (srst)
      (phase == PH_EAV) |=> ((phase == PH_EAV) || (phase == PH_HBL)));

   assert_sav_hold_R5: assert property (@(posedge clk) disable iff (srst)
      (phase == PH_SAV) |=> ((phase == PH_SAV) || (phase == PH_ACT)));

   assert_act_hold_R5: assert property (@(posedge clk) disable iff (srst)
      (phase == PH_ACT) |=> ((phase == PH_ACT) || (phase == PH_EAV)));

   assert_no_ref_data_R7: assert property (@(posedge clk) disable iff (srst)
      ((CLIP_EN != 0) && (phase == PH_ACT)) |=> ((byte_out != 8'h00) && (byte_out != 8'hFF)));

   assert_line_range_R10: assert property (@(posedge clk) disable iff (srst)
      (advance || !advance) |-> ((line != '0) && (line <= LINE_W'(625))));

   assert_line_step_R10: assert property (@(posedge clk) disable iff (srst)
      advance |=> ((line == $past(line) + LINE_W'(1)) || (line == LINE_W'(1))));

endmodule

bind bt656_fmt bt656_fmt_chk #(.CLIP_EN(CLIP_EN)) i_bt656_fmt_chk (
   .clk      (clk),
   .srst     (srst),
   .byte_out (byte_out),
   .phase    (phase),
   .line     (line),
   .advance  (advance)
);

// File: tb/test_bt656_fmt.sv
module test_bt656_fmt;

   localparam int ACT = 8;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       sys625 = 1'b0;
   logic       line_end = 1'b0;
   logic       pix_valid = 1'b0;
   logic [7:0] pix_y = 8'h00;
   logic [7:0] pix_c = 8'h00;
   logic [7:0] byte_out;

   int total = 0;
   int bad = 0;
   int exp_line = 1;

   logic [7:0] drv_c [ACT];
   logic [7:0] drv_y [ACT];
   logic       drv_v [ACT];

   always #10 clk = ~clk;

   bt656_fmt #(.ACT_BYTES(ACT)) i_bt656_fmt (
      .clk       (clk),
      .srst      (srst),
      .sys625    (sys625),
      .line_end  (line_end),
      .pix_valid (pix_valid),
      .pix_y     (pix_y),
      .pix_c     (pix_c),
      .byte_out  (byte_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s line %0d: got %02h expected %02h", req, exp_line, act, exp);
      end
   endtask

   function automatic void exp_fv(input bit s625, input int ln, output bit f, output bit v);
      if (s625) begin
         f = (ln >= 313);
         v = !(((ln >= 23) && (ln <= 310)) || ((ln >= 336) && (ln <= 623)));
      end else begin
         f = !((ln >= 4) && (ln <= 265));
         v = !(((ln >= 20) && (ln <= 259)) || ((ln >= 283) && (ln <= 522)));
      end
   endfunction

   function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
      xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic logic [7:0] clipb(input logic [7:0] b);
      if (b == 8'h00) return 8'h01;
      if (b == 8'hFF) return 8'hFE;
      return b;
   endfunction

   function automatic logic [7:0] lvl(input int k);
      return (k % 2 != 0) ? 8'h10 : 8'h80;
   endfunction

   // One whole line: nbl blanking bytes, data mode, spurious strobes
   task automatic run_line(input int nbl, input int mode, input bit spur);
      int         tot;
      bit         f, v;
      logic [7:0] e;
      string      req;
      tot = 8 + nbl + ACT;
      exp_fv(sys625, exp_line, f, v);
      for (int p = 0; p < tot; p++) begin
         int q;
         @(negedge clk);
         if (p < 4) begin
            e   = (p == 0) ? 8'hFF : (p == 3) ? xy(f, v, 1'b1) : 8'h00;
            req = (p == 3) ? (sys625 ? "R9" : "R8") : "R2";
         end else if (p < 4 + nbl) begin
            e   = lvl(p - 4);
            req = spur ? "R5" : "R4";
         end else if (p < 8 + nbl) begin
            e   = (p == 4 + nbl) ? 8'hFF : (p == 7 + nbl) ? xy(f, v, 1'b0) : 8'h00;
            req = (p == 4 + nbl) ? "R3" : "R2";
         end else begin
            int a;
            a = p - 8 - nbl;
            if (v) begin
               e = lvl(a); req = "R4";
            end else if (!drv_v[a]) begin
               e = lvl(a); req = "R6";
            end else begin
               e   = (a % 2 != 0) ? clipb(drv_y[a]) : clipb(drv_c[a]);
               req = (mode == 1) ? "R7" : "R6";
            end
         end
         chk(req, byte_out, e);
         q = p + 1;
         line_end = (q == 3 + nbl) || (spur && ((q < 4) || (q >= 4 + nbl)));
         if ((q >= 8 + nbl) && (q < tot)) begin
            int a;
            a = q - 8 - nbl;
            case (mode)
               1: begin
                  pix_c = (a % 4 == 0) ? 8'h00 : 8'hFF;
                  pix_y = (a % 4 == 1) ? 8'hFF : 8'h00;
                  pix_valid = 1'b1;
               end
               2: begin
                  pix_c = 8'(a * 29 + exp_line);
                  pix_y = 8'(90 + a * 7 + exp_line);
                  pix_valid = (a % 3 != 0);
               end
               default: begin
                  pix_c = 8'(a * 17 + exp_line);
                  pix_y = 8'(200 - a * 9 + exp_line);
                  pix_valid = 1'b1;
               end
            endcase
            drv_c[a] = pix_c;
            drv_y[a] = pix_y;
            drv_v[a] = pix_valid;
         end else begin
            pix_valid = 1'b0;
         end
      end
      exp_line = (exp_line >= (sys625 ? 625 : 525)) ? 1 : exp_line + 1;
   endtask

   task automatic do_reset(input bit s625);
      @(negedge clk);
      srst = 1'b1;
      sys625 = s625;
      line_end = 1'b0;
      pix_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", byte_out, 8'h10);
      srst = 1'b0;
      exp_line = 1;
   endtask

   // R8 and R10: full 525 frame, varied blanking, then past the wrap
   task automatic test_frame525();
      do_reset(1'b0);
      for (int i = 0; i < 525 + 25; i++) run_line(1 + (i % 7), 0, 1'b0);
   endtask

   // R9, R5, R7: full 625 frame, strobes outside blanking, extreme data
   task automatic test_frame625();
      do_reset(1'b1);
      for (int i = 0; i < 625 + 30; i++) run_line(1 + (i % 5) * 3, (i % 2 != 0) ? 1 : 2, 1'b1);
   endtask

   // R1 and R3: long blanking, then a reset in the middle of a line
   task automatic test_midreset();
      do_reset(1'b0);
      for (int i = 0; i < 30; i++) run_line((i % 2 != 0) ? 21 : 40, 0, 1'b0);
      repeat (6) @(negedge clk);
      do_reset(1'b1);
      for (int i = 0; i < 4; i++) run_line(2, 0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      test_frame525();
      test_frame625();
      test_midreset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule